// File: doc/BRIEF.md
# Indirect Memory-Controller Configuration Register Bank

This block holds the configuration and status registers of a four-bank memory controller. Software reaches them through two locations on a narrow register bus. An index port holds a 32-bit selector. A data port reads or writes whichever internal register that selector names. Each internal register has its own write mask. Some registers force bits to fixed values, two error words clear on a write of ones, and a status word follows edges of two configuration bits.

Four bank words each describe one memory region: an enable, a base address aligned to 8 MiB, and a size code. The block decodes them into a per-bank hit vector for an incoming system address, qualified by the global controller enable. An ECC error word drives an interrupt line that stays high while the word is nonzero.

Top module: `memcfg_regbank`

## Requirements
- R1: A write to bus address 0x10 stores the index. A read there returns the index. Bus address 0x11 reads or writes the internal register the index selects. Any other bus address reads 0 and its writes change nothing.
- R2: After reset the registers read as follows. Index, error words, error address, status, ECC configuration and ECC error all read 0. Configuration reads 0x00800000, refresh 0x05F00000, power timer 0x07C00000. Banks read 0, ecc_irq is 0 and bank_hit is 0.
- R3: Configuration (offset 0x20) stores the write data ANDed with 0xFFE00000. A 0-to-1 change of its bit 31 clears status bit 31. A 1-to-0 change sets status bit 31.
- R4: A 0-to-1 change of configuration bit 30 sets status bit 30, and a 1-to-0 change clears it. Status (offset 0x24) ignores writes and changes only through these edges.
- R5: Bank words sit at offsets 0x40, 0x44, 0x48 and 0x4C for banks 0 to 3. Each stores the write data ANDed with 0xFFDEE001. Bit 0 is the enable, bits 31:23 are the base address bits 31:23, and bits 19:17 are a size code.
- R6: bank_hit[n] is 1 exactly when all of these hold: configuration bit 31 is 1, bank n bit 0 is 1, its size code c is not 7, and sys_addr lies in [base, base + (4 MiB << c)).
- R7: Refresh (0x30) stores the data ANDed with 0x3FF80000. ECC configuration (0x94) stores it ANDed with 0x00F00000. Power timer (0x34) stores data bits 31:27 and always reads bits 26:22 as 1 and all other bits as 0.
- R8: A read of the timing offset 0x80 returns 0xFFFFFFFF. Any offset not named in R3 to R10 reads 0xFFFFFFFF, and writes to it change nothing.
- R9: ECC error (0x98) stores the data ANDed with 0xFFF0F000. ecc_irq is 1 exactly while that register is nonzero and changes on the same edge as the register.
- R10: The error words at 0x00 and 0x08 clear the bits written as 1 and keep the others. The error address at 0x10 stores the full write value.
- R11: A write takes effect on the clock edge where bus_sel and bus_we are high, and is visible on reads and outputs after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Bus register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr and state |
| sys_addr | input | 32 | System address to match against the banks |
| bank_hit | output | N_BANKS | Per-bank address match |
| ecc_irq | output | 1 | ECC error interrupt |

## Verification
The assertions assume that the bus holds one access per strobed cycle. They also assume that bus_addr and bus_wdata are stable around the edge, and that reset is applied before any access. The bench drives every input at the falling edge and releases the strobe one cycle later, so each write lands on exactly one rising edge. Random offsets are drawn from the mapped set plus two unmapped offsets. Random bank words use addresses near each configured base, so that both region edges and the invalid size code get exercised.

// File: rtl/memcfg_pkg.sv
package memcfg_pkg;

    typedef logic [31:0] word_t;

    // internal register offsets (selected by the index register)
    localparam word_t OFF_ERRST0  = 32'h0000_0000;
    localparam word_t OFF_ERRST1  = 32'h0000_0008;
    localparam word_t OFF_ERRADDR = 32'h0000_0010;
    localparam word_t OFF_CFG     = 32'h0000_0020;
    localparam word_t OFF_STATUS  = 32'h0000_0024;
    localparam word_t OFF_REFRESH = 32'h0000_0030;
    localparam word_t OFF_PMT     = 32'h0000_0034;
    localparam word_t OFF_BANK0   = 32'h0000_0040;
    localparam word_t OFF_TIMING  = 32'h0000_0080;
    localparam word_t OFF_ECCCFG  = 32'h0000_0094;
    localparam word_t OFF_ECCERR  = 32'h0000_0098;
    localparam int unsigned BANK_STRIDE = 4;

    // write masks and forced bits
    localparam word_t MASK_CFG      = 32'hFFE0_0000;
    localparam word_t MASK_BANK     = 32'hFFDE_E001;
    localparam word_t MASK_REFRESH  = 32'h3FF8_0000;
    localparam word_t MASK_PMT_KEEP = 32'hF800_0000;
    localparam word_t PMT_FORCE     = 32'h07C0_0000;
    localparam word_t MASK_TIMING   = 32'h018F_C01F;
    localparam word_t MASK_ECCCFG   = 32'h00F0_0000;
    localparam word_t MASK_ECCERR   = 32'hFFF0_F000;

    // reset values
    localparam word_t RST_CFG     = 32'h0080_0000;
    localparam word_t RST_REFRESH = 32'h05F0_0000;
    localparam word_t RST_PMT     = 32'h07C0_0000;
    localparam word_t RST_TIMING  = 32'h0085_4009;

    // bit positions with behaviour attached
    localparam int unsigned BIT_CTL_EN   = 31;
    localparam int unsigned BIT_CTL_AUX  = 30;
    localparam int unsigned BANK_EN_BIT  = 0;
    localparam int unsigned BANK_BASE_LO = 23;
    localparam int unsigned BANK_CODE_LO = 17;
    localparam int unsigned BANK_CODE_W  = 3;
    localparam int unsigned SIZE_UNIT_LG = 22;  // 4 MiB

    typedef struct packed {
        word_t index;
        word_t errst0;
        word_t errst1;
        word_t erraddr;
        word_t cfg;
        word_t status;
        word_t refresh;
        word_t pmt;
        word_t timing;
        word_t ecccfg;
        word_t eccerr;
        logic  irq;
    } regs_t;

endpackage

// File: rtl/memcfg_bank_decode.sv
module memcfg_bank_decode
    import memcfg_pkg::*;
(
    input  word_t       word,
    input  logic        ctl_en,
    input  logic [31:0] sys_addr,
    output logic        hit
);
    localparam logic [BANK_CODE_W-1:0] CODE_BAD = '1;

    logic [BANK_CODE_W-1:0] code;
    logic [32:0]            base;
    logic [32:0]            size;
    logic [32:0]            addr_x;
    logic                   unused_bits;

    assign unused_bits = ^{word[BANK_BASE_LO-1:BANK_CODE_LO+BANK_CODE_W],
                           word[BANK_CODE_LO-1:BANK_EN_BIT+1]};

    always_comb begin
        code   = word[BANK_CODE_LO +: BANK_CODE_W];
        base   = {1'b0, word[31:BANK_BASE_LO], {BANK_BASE_LO{1'b0}}};
        size   = 33'd1 << (SIZE_UNIT_LG + 32'(code));
        addr_x = {1'b0, sys_addr};
        hit    = ctl_en && word[BANK_EN_BIT] && (code != CODE_BAD)
                 && (addr_x >= base) && (addr_x < base + size);
    end
endmodule

// File: rtl/memcfg_rdmux.sv
module memcfg_rdmux
    import memcfg_pkg::*;
#(
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned N_BANKS   = 4,
    parameter logic [ADDR_W-1:0] IDX_PORT  = 'h10,
    parameter logic [ADDR_W-1:0] DATA_PORT = 'h11
) (
    input  regs_t                     st,
    input  logic [N_BANKS-1:0][31:0]  banks,
    input  logic [ADDR_W-1:0]         bus_addr,
    output word_t                     rdata
);
    word_t sel_val;
    wire   unused_rd = ^{st.timing, st.irq};

    always_comb begin
        sel_val = '1;
        case (st.index)
            OFF_ERRST0:  sel_val = st.errst0;
            OFF_ERRST1:  sel_val = st.errst1;
            OFF_ERRADDR: sel_val = st.erraddr;
            OFF_CFG:     sel_val = st.cfg;
            OFF_STATUS:  sel_val = st.status;
            OFF_REFRESH: sel_val = st.refresh;
            OFF_PMT:     sel_val = st.pmt;
            OFF_TIMING:  sel_val = '1;
            OFF_ECCCFG:  sel_val = st.ecccfg;
            OFF_ECCERR:  sel_val = st.eccerr;
            default:     sel_val = '1;
        endcase
        for (int n = 0; n < N_BANKS; n++) begin
            if (st.index == OFF_BANK0 + 32'(BANK_STRIDE * n))
                sel_val = banks[n];
        end

        if (bus_addr == IDX_PORT)       rdata = st.index;
        else if (bus_addr == DATA_PORT) rdata = sel_val;
        else                            rdata = '0;
    end
endmodule

// File: rtl/memcfg_regbank.sv
module memcfg_regbank
    import memcfg_pkg::*;
#(
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned N_BANKS   = 4,
    parameter logic [ADDR_W-1:0] IDX_PORT  = 'h10,
    parameter logic [ADDR_W-1:0] DATA_PORT = 'h11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [31:0]        sys_addr,
    output logic [N_BANKS-1:0] bank_hit,
    output logic               ecc_irq
);
    regs_t                    st_d, st_q;
    logic [N_BANKS-1:0][31:0] bank_d, bank_q;
    logic                     wr_idx, wr_dat;
    word_t                    cfg_new;

    always_comb begin
        st_d    = st_q;
        bank_d  = bank_q;
        cfg_new = bus_wdata & MASK_CFG;
        wr_idx  = bus_sel && bus_we && (bus_addr == IDX_PORT);
        wr_dat  = bus_sel && bus_we && (bus_addr == DATA_PORT);

        if (wr_idx)
            st_d.index = bus_wdata;

        if (wr_dat) begin
            case (st_q.index)
                OFF_ERRST0:  st_d.errst0  = st_q.errst0 & ~bus_wdata;
                OFF_ERRST1:  st_d.errst1  = st_q.errst1 & ~bus_wdata;
                OFF_ERRADDR: st_d.erraddr = bus_wdata;
                OFF_CFG: begin
                    if (!st_q.cfg[BIT_CTL_EN] && cfg_new[BIT_CTL_EN])
                        st_d.status[BIT_CTL_EN] = 1'b0;
                    else if (st_q.cfg[BIT_CTL_EN] && !cfg_new[BIT_CTL_EN])
                        st_d.status[BIT_CTL_EN] = 1'b1;
                    if (!st_q.cfg[BIT_CTL_AUX] && cfg_new[BIT_CTL_AUX])
                        st_d.status[BIT_CTL_AUX] = 1'b1;
                    else if (st_q.cfg[BIT_CTL_AUX] && !cfg_new[BIT_CTL_AUX])
                        st_d.status[BIT_CTL_AUX] = 1'b0;
                    st_d.cfg = cfg_new;
                end
                OFF_REFRESH: st_d.refresh = bus_wdata & MASK_REFRESH;
                OFF_PMT:     st_d.pmt     = (bus_wdata & MASK_PMT_KEEP) | PMT_FORCE;
                OFF_TIMING:  st_d.timing  = bus_wdata & MASK_TIMING;
                OFF_ECCCFG:  st_d.ecccfg  = bus_wdata & MASK_ECCCFG;
                OFF_ECCERR:  st_d.eccerr  = bus_wdata & MASK_ECCERR;
                default: ;
            endcase
            for (int n = 0; n < N_BANKS; n++) begin
                if (st_q.index == OFF_BANK0 + 32'(BANK_STRIDE * n))
                    bank_d[n] = bus_wdata & MASK_BANK;
            end
        end

        st_d.irq = (st_d.eccerr != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.cfg     <= RST_CFG;
            st_q.refresh <= RST_REFRESH;
            st_q.pmt     <= RST_PMT;
            st_q.timing  <= RST_TIMING;
            bank_q       <= '0;
        end else begin
            st_q   <= st_d;
            bank_q <= bank_d;
        end
    end

    assign ecc_irq = st_q.irq;

    for (genvar g = 0; g < N_BANKS; g++) begin : g_bank
        memcfg_bank_decode u_dec (
            .word     (bank_q[g]),
            .ctl_en   (st_q.cfg[BIT_CTL_EN]),
            .sys_addr (sys_addr),
            .hit      (bank_hit[g])
        );
    end

    memcfg_rdmux #(
        .ADDR_W    (ADDR_W),
        .N_BANKS   (N_BANKS),
        .IDX_PORT  (IDX_PORT),
        .DATA_PORT (DATA_PORT)
    ) u_rd (
        .st       (st_q),
        .banks    (bank_q),
        .bus_addr (bus_addr),
        .rdata    (bus_rdata)
    );
endmodule

// File: rtl/memcfg_checker.sv
module memcfg_checker
    import memcfg_pkg::*;
#(
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned N_BANKS   = 4,
    parameter logic [ADDR_W-1:0] IDX_PORT  = 'h10,
    parameter logic [ADDR_W-1:0] DATA_PORT = 'h11
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_we,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [31:0]        bus_wdata,
    input logic [31:0]        bus_rdata,
    input logic [N_BANKS-1:0] bank_hit,
    input logic               ecc_irq,
    input regs_t              st_q
);
    wire unused_chk = ^st_q;
    logic wr_ecc;
    assign wr_ecc = bus_sel && bus_we && (bus_addr == DATA_PORT)
                    && (st_q.index == OFF_ECCERR);

    // R9: nonzero masked write raises the interrupt on the next edge
    a_r9_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ecc && ((bus_wdata & MASK_ECCERR) != '0)) |=> ecc_irq);
    // R9: zero masked write drops the interrupt
    a_r9_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ecc && ((bus_wdata & MASK_ECCERR) == '0)) |=> !ecc_irq);
    // R6: no hit while the controller is disabled
    a_r6_hit_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_hit != '0) |-> st_q.cfg[BIT_CTL_EN]);
    // R3: enable edges drive status bit 31
    a_r3_enable_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.cfg[BIT_CTL_EN]) |-> !st_q.status[BIT_CTL_EN]);
    a_r3_enable_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.cfg[BIT_CTL_EN]) |-> st_q.status[BIT_CTL_EN]);
    // R4: bit 30 edges drive status bit 30
    a_r4_aux_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.cfg[BIT_CTL_AUX]) |-> st_q.status[BIT_CTL_AUX]);
    a_r4_aux_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.cfg[BIT_CTL_AUX]) |-> !st_q.status[BIT_CTL_AUX]);
    // R4: status moves only with configuration
    a_r4_status_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(st_q.cfg) |-> $stable(st_q.status));
    // R7: forced power-timer bits
    a_r7_pmt_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pmt & PMT_FORCE) == PMT_FORCE);
    // R8: timing offset reads all ones
    a_r8_timing_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == DATA_PORT && st_q.index == OFF_TIMING) |-> (bus_rdata == '1));
    // R1: other bus addresses read zero
    a_r1_other_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != DATA_PORT && bus_addr != IDX_PORT) |-> (bus_rdata == '0));
endmodule

bind memcfg_regbank memcfg_checker #(
    .ADDR_W    (ADDR_W),
    .N_BANKS   (N_BANKS),
    .IDX_PORT  (IDX_PORT),
    .DATA_PORT (DATA_PORT)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bank_hit  (bank_hit),
    .ecc_irq   (ecc_irq),
    .st_q      (st_q)
);

// File: tb/memcfg_regbank_tb.sv
module memcfg_regbank_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 10;
    localparam int NB = 4;
    localparam logic [ADDR_W-1:0] IDXP = 'h10;
    localparam logic [ADDR_W-1:0] DATP = 'h11;

    logic              clk = 0;
    logic              rst_n = 0;
    logic              bus_sel = 0, bus_we = 0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0, sys_addr = '0;
    logic [31:0]       bus_rdata;
    logic [NB-1:0]     bank_hit;
    logic              ecc_irq;

    int checks = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    memcfg_regbank #(.ADDR_W(ADDR_W), .N_BANKS(NB), .IDX_PORT(IDXP), .DATA_PORT(DATP)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sys_addr(sys_addr), .bank_hit(bank_hit), .ecc_irq(ecc_irq));

    // reference model state
    logic [31:0] m_idx, m_e0, m_e1, m_ea, m_cfg, m_st, m_rf, m_pm, m_ec, m_ee;
    logic [31:0] m_bank [NB];

    task automatic model_reset();
        m_idx = 0; m_e0 = 0; m_e1 = 0; m_ea = 0; m_cfg = 32'h0080_0000; m_st = 0;
        m_rf = 32'h05F0_0000; m_pm = 32'h07C0_0000; m_ec = 0; m_ee = 0;
        for (int n = 0; n < NB; n++) m_bank[n] = 0;
    endtask

    task automatic model_write(input logic [31:0] off, input logic [31:0] v);
        logic [31:0] nc;
        case (off)
            32'h00: m_e0 = m_e0 & ~v;
            32'h08: m_e1 = m_e1 & ~v;
            32'h10: m_ea = v;
            32'h20: begin
                nc = v & 32'hFFE0_0000;
                if (!m_cfg[31] && nc[31]) m_st[31] = 0;
                if (m_cfg[31] && !nc[31]) m_st[31] = 1;
                if (!m_cfg[30] && nc[30]) m_st[30] = 1;
                if (m_cfg[30] && !nc[30]) m_st[30] = 0;
                m_cfg = nc;
            end
            32'h30: m_rf = v & 32'h3FF8_0000;
            32'h34: m_pm = (v & 32'hF800_0000) | 32'h07C0_0000;
            32'h94: m_ec = v & 32'h00F0_0000;
            32'h98: m_ee = v & 32'hFFF0_F000;
            default: ;
        endcase
        for (int n = 0; n < NB; n++)
            if (off == 32'h40 + 32'(4*n)) m_bank[n] = v & 32'hFFDE_E001;
    endtask

    function automatic logic [31:0] exp_read(input logic [31:0] off);
        logic [31:0] r;
        case (off)
            32'h00: r = m_e0;  32'h08: r = m_e1;  32'h10: r = m_ea;
            32'h20: r = m_cfg; 32'h24: r = m_st;  32'h30: r = m_rf;
            32'h34: r = m_pm;  32'h94: r = m_ec;  32'h98: r = m_ee;
            default: r = 32'hFFFF_FFFF;
        endcase
        for (int n = 0; n < NB; n++)
            if (off == 32'h40 + 32'(4*n)) r = m_bank[n];
        return r;
    endfunction

    function automatic string req_of(input logic [31:0] off);
        case (off)
            32'h00, 32'h08, 32'h10: return "R10";
            32'h20: return "R3";
            32'h24: return "R4";
            32'h30, 32'h34, 32'h94: return "R7";
            32'h40, 32'h44, 32'h48, 32'h4C: return "R5";
            32'h98: return "R9";
            default: return "R8";
        endcase
    endfunction

    function automatic logic [NB-1:0] exp_hit(input logic [31:0] a);
        logic [NB-1:0] h;
        logic [63:0] base, sz;
        for (int n = 0; n < NB; n++) begin
            base = {32'd0, m_bank[n][31:23], 23'd0};
            sz   = 64'd4194304 << m_bank[n][19:17];
            h[n] = m_cfg[31] && m_bank[n][0] && (m_bank[n][19:17] != 3'd7)
                   && ({32'd0, a} >= base) && ({32'd0, a} < base + sz);
        end
        return h;
    endfunction

    function automatic logic [31:0] pick_off(input int k);
        case (k)
            0: return 32'h00;  1: return 32'h08;  2: return 32'h10;  3: return 32'h20;
            4: return 32'h24;  5: return 32'h30;  6: return 32'h34;  7: return 32'h40;
            8: return 32'h44;  9: return 32'h48; 10: return 32'h4C; 11: return 32'h80;
           12: return 32'h94; 13: return 32'h98; 14: return 32'h04;
           default: return 32'h50;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic reg_write(input logic [31:0] off, input logic [31:0] v);
        bus_write(IDXP, off);
        m_idx = off;
        bus_write(DATP, v);
        model_write(off, v);
    endtask

    task automatic reg_check(input logic [31:0] off);
        logic [31:0] r;
        bus_write(IDXP, off);
        m_idx = off;
        bus_read(DATP, r);
        chk(req_of(off), r, exp_read(off));
    endtask

    task automatic hit_check(input string req, input logic [31:0] a);
        @(negedge clk);
        sys_addr = a;
        #1 chk(req, 32'(bank_hit), 32'(exp_hit(a)));
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R2: reset state
        bus_read(IDXP, r); chk("R2 index", r, 32'h0);
        chk("R2 irq", 32'(ecc_irq), 0);
        chk("R2 hit", 32'(bank_hit), 0);
        for (int k = 0; k < 16; k++) reg_check(pick_off(k));

        // R1: index port readback, other addresses read zero and ignore writes
        bus_write(IDXP, 32'h0000_0020); m_idx = 32'h20;
        bus_read(IDXP, r); chk("R1 index", r, 32'h20);
        bus_write(10'h12, 32'h0000_0030);
        bus_read(IDXP, r); chk("R1 stray write", r, 32'h20);
        bus_read(DATP, r); chk("R1 data", r, m_cfg);
        bus_read(10'h12, r); chk("R1 other read", r, 32'h0);

        // R3/R4: enable and aux edges
        reg_write(32'h20, 32'hC0FF_FFFF);
        reg_check(32'h20); reg_check(32'h24);
        reg_write(32'h24, 32'hFFFF_FFFF); reg_check(32'h24);
        reg_write(32'h20, 32'h0000_0000);
        reg_check(32'h24);
        bus_read(DATP, r); chk("R4 status after fall", r, 32'h8000_0000);
        reg_write(32'h20, 32'h8000_0000);

        // R5/R6: bank decode boundaries
        reg_write(32'h40, 32'h0000_0001);
        reg_write(32'h44, 32'h008C_0001);
        reg_write(32'h48, 32'h200E_0001);
        reg_write(32'h4C, 32'hFFFF_FFFE);
        reg_check(32'h4C);
        hit_check("R6 b0 top", 32'h003F_FFFF);
        hit_check("R6 b0 past", 32'h0040_0000);
        hit_check("R6 b1 low", 32'h0080_0000);
        hit_check("R6 b1 top", 32'h107F_FFFF);
        hit_check("R6 b1 past", 32'h1080_0000);
        hit_check("R6 code7", 32'h2000_0000);
        chk("R6 b1 top direct", 32'(exp_hit(32'h107F_FFFF)), 32'h2);
        reg_write(32'h20, 32'h0);
        hit_check("R6 disabled", 32'h0000_1000);

        // R9/R10/R11: ECC interrupt and clear-on-one
        reg_write(32'h98, 32'h000F_0FFF);
        chk("R9 masked zero irq", 32'(ecc_irq), 0);
        bus_write(IDXP, 32'h98);
        @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = DATP; bus_wdata = 32'h0010_0000;
        #1 chk("R11 before edge", 32'(ecc_irq), 0);
        @(negedge clk); bus_sel = 0; bus_we = 0; model_write(32'h98, 32'h0010_0000);
        chk("R9 irq set", 32'(ecc_irq), 1);
        reg_write(32'h98, 32'h0);
        chk("R9 irq clear", 32'(ecc_irq), 0);
        reg_write(32'h08, 32'hFFFF_FFFF); reg_check(32'h08);
        reg_write(32'h10, 32'h1234_5678); reg_check(32'h10);

        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [31:0] off, v, a, base;
            int bn;
            off = pick_off(int'($urandom % 16));
            v = $urandom;
            reg_write(off, v);
            reg_check(off);
            chk("R9 irq random", 32'(ecc_irq), 32'(m_ee != 0));
            bn = int'($urandom % NB);
            base = {m_bank[bn][31:23], 23'd0};
            a = base + ($urandom % (32'h0080_0000 << ($urandom % 6))) - 32'h10;
            hit_check("R6 random", a);
        end

        for (int k = 0; k < 16; k++) reg_check(pick_off(k));
        finish_run();
    end
endmodule